// File: doc/BRIEF.md
# T1 Receive Link and Signaling Extractor

This block sits behind the line interface of a T1 receiver. It samples a dual-rail unipolar line on the falling clock edge and merges the two rails into one NRZ bit. It raises a one-cycle flag when the line breaks the alternate-mark-inversion rule. The merged bit stream leaves the block on a serial output with a fixed delay. Two side outputs carry the stream's control content: the least significant bit of every 8-bit channel word, and the link bit that the chosen framing mode assigns to alternate frames.

The block does no framing search of its own. An external timing counter supplies, in every clock period, the bit position and frame number of the bit that the serial output will show after the next rising edge. Bit position 0 is the framing bit. Channel c occupies positions 1+8c (MSB) to 8+8c (LSB), and the last position is 192. Frames are numbered from 0. A mode input selects a 12-frame superframe or a 24-frame extended superframe.

If both rails are wired together, the line carries plain NRZ data. The block recognises this from a run of double-rail marks and then stops flagging violations.

Top module: `t1_rx_extract`

## Requirements
- R1: The rails are sampled on the falling clock edge. The data bit is the OR of the positive and negative rail.
- R2: The bit sampled in clock period n appears on serOut throughout period n+13. It is updated on the rising edge, one bit per clock.
- R3: On the rising edge where serOut takes a channel MSB, sigOut takes that channel's LSB. It then holds: 8 periods, or 9 when the framing bit follows channel 23.
- R4: sigOut carries the channel LSB in every frame of the superframe, not only in signaling frames.
- R5: With esfMode=0 (frames 0 to 11), linkOut carries the framing bit of the odd-numbered frames 1, 3, ..., 11.
- R6: With esfMode=1 (frames 0 to 23), linkOut carries the framing bit of the even-numbered frames 0, 2, ..., 22.
- R7: linkOut changes one bit period before its frame starts, on the edge where serOut takes bit 192 of the frame before. It is then held for two frames.
- R8: Two successive single-rail marks of the same polarity cause bpvFlag to be high for the one period after the offending bit's sampling period.
- R9: A bit with both rails high is flagged on bpvFlag in the same way, unless the tied-rail state of R10 holds.
- R10: After 4 consecutive marks with both rails high, later double-rail marks are not flagged. A single-rail mark clears this state. Zeros leave it unchanged.
- R11: While rst_n is low, serOut, sigOut, linkOut and bpvFlag are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| linePos | input | 1 | Positive-mark rail |
| lineNeg | input | 1 | Negative-mark rail |
| esfMode | input | 1 | 0: 12-frame superframe, 1: 24-frame extended superframe |
| posBit | input | 8 | Position in the frame (0 to 192) of the bit serOut shows next |
| posFrame | input | 5 | Frame number of that bit |
| serOut | output | 1 | Delayed NRZ data |
| sigOut | output | 1 | Held LSB of the current channel word |
| linkOut | output | 1 | Held link bit |
| bpvFlag | output | 1 | Bipolar violation pulse |

## Verification
A bipolar violation can land on the framing bit of a link frame. In that case one line bit feeds the violation pulse, the serial output and the held link bit all at once. The superframe run forces a mark with repeated polarity onto the framing bit of frame 3. That bit is loaded into linkOut one period before serOut shows it. The bench checks, cycle by cycle, that bpvFlag pulses for exactly one period after the bit was sampled. It also checks that serOut and linkOut still carry the merged data value, so the violation does not corrupt either one.

// File: rtl/t1rx_pkg.sv
package t1rx_pkg;

  // Load strobes from the control decode to the datapath registers.
  typedef struct packed {
    logic sigLoad;   // serOut takes a channel MSB at the next edge
    logic linkLoad;  // serOut takes bit 192 before a link frame
  } t1rx_strobe_t;

  localparam int SF_FRAMES  = 12;
  localparam int ESF_FRAMES = 24;

endpackage

// File: rtl/t1rx_ctrl.sv
module t1rx_ctrl
  import t1rx_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  parameter int CHAN_BITS  = 8,
  localparam int BIT_W = $clog2(FRAME_BITS),
  localparam int FRM_W = $clog2(ESF_FRAMES)
) (
  input  logic             esfMode,
  input  logic [BIT_W-1:0] posBit,
  input  logic [FRM_W-1:0] posFrame,
  output t1rx_strobe_t     strobe
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [FRM_W-1:0] SF_LAST  = FRM_W'(SF_FRAMES - 1);
  localparam logic [FRM_W-1:0] ESF_LAST = FRM_W'(ESF_FRAMES - 1);

  logic [BIT_W-1:0] chanOfs;
  logic [FRM_W-1:0] lastFrame;
  logic [FRM_W-1:0] nextFrame;
  logic             nextIsLink;

  always_comb begin
    chanOfs   = posBit - BIT_W'(1);
    lastFrame = esfMode ? ESF_LAST : SF_LAST;
    nextFrame = (posFrame == lastFrame) ? '0 : posFrame + FRM_W'(1);
    // Extended superframe: link on even frames; superframe: on odd frames.
    nextIsLink = esfMode ? ~nextFrame[0] : nextFrame[0];

    strobe.sigLoad  = (posBit != '0) &&
                      ((32'(chanOfs) % CHAN_BITS) == 0);
    strobe.linkLoad = (posBit == LAST_BIT) && nextIsLink;
  end

endmodule

// File: rtl/t1rx_line_mon.sv
module t1rx_line_mon #(
  parameter int TIE_RUN = 4,
  localparam int TIE_W = $clog2(TIE_RUN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic linePos,
  input  logic lineNeg,
  output logic dataSmp,
  output logic violSmp
);

  localparam logic [TIE_W-1:0] TIE_MAX = TIE_W'(TIE_RUN);

  logic             lastPol;
  logic             hadMark;
  logic [TIE_W-1:0] tieCnt;
  logic             singleMark;
  logic             doubleMark;
  logic             violNow;

  always_comb begin
    singleMark = linePos ^ lineNeg;
    doubleMark = linePos & lineNeg;
    violNow    = (singleMark && hadMark && (linePos == lastPol)) ||
                 (doubleMark && (tieCnt < TIE_MAX));
  end

  // Rails are sampled on the falling edge, mid-bit.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataSmp <= 1'b0;
      violSmp <= 1'b0;
      lastPol <= 1'b0;
      hadMark <= 1'b0;
      tieCnt  <= '0;
    end else begin
      dataSmp <= linePos | lineNeg;
      violSmp <= violNow;
      if (singleMark) begin
        lastPol <= linePos;
        hadMark <= 1'b1;
        tieCnt  <= '0;
      end else if (doubleMark && (tieCnt < TIE_MAX)) begin
        tieCnt <= tieCnt + TIE_W'(1);
      end
    end
  end

endmodule

// File: rtl/t1rx_dpath.sv
module t1rx_dpath
  import t1rx_pkg::*;
#(
  parameter int LATENCY   = 13,
  parameter int CHAN_BITS = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dataSmp,
  input  logic         violSmp,
  input  t1rx_strobe_t strobe,
  output logic         serOut,
  output logic         sigOut,
  output logic         linkOut,
  output logic         bpvFlag
);

  // pipe[k] holds the bit sampled k periods ago; serOut is stage LATENCY.
  localparam int NEXT_TAP = LATENCY - 1;
  localparam int LINK_TAP = LATENCY - 2;
  localparam int SIG_TAP  = LATENCY - CHAN_BITS;

  logic [LATENCY-1:1] pipe;

  generate
    if (LATENCY > 2) begin : g_long
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[LATENCY-2:1], dataSmp};
      end
    end else begin : g_short
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= dataSmp;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serOut  <= 1'b0;
      sigOut  <= 1'b0;
      linkOut <= 1'b0;
      bpvFlag <= 1'b0;
    end else begin
      serOut  <= pipe[NEXT_TAP];
      bpvFlag <= violSmp;
      if (strobe.sigLoad)  sigOut  <= pipe[SIG_TAP];
      if (strobe.linkLoad) linkOut <= pipe[LINK_TAP];
    end
  end

endmodule

// File: rtl/t1_rx_extract.sv
module t1_rx_extract
  import t1rx_pkg::*;
#(
  parameter int LATENCY    = 13,
  parameter int FRAME_BITS = 193,
  parameter int CHAN_BITS  = 8,
  parameter int TIE_RUN    = 4,
  localparam int BIT_W = $clog2(FRAME_BITS),
  localparam int FRM_W = $clog2(ESF_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             linePos,
  input  logic             lineNeg,
  input  logic             esfMode,
  input  logic [BIT_W-1:0] posBit,
  input  logic [FRM_W-1:0] posFrame,
  output logic             serOut,
  output logic             sigOut,
  output logic             linkOut,
  output logic             bpvFlag
);

  t1rx_strobe_t strobe;
  logic         dataSmp;
  logic         violSmp;

  t1rx_ctrl #(.FRAME_BITS(FRAME_BITS), .CHAN_BITS(CHAN_BITS)) u_ctrl (
    .esfMode (esfMode),
    .posBit  (posBit),
    .posFrame(posFrame),
    .strobe  (strobe)
  );

  t1rx_line_mon #(.TIE_RUN(TIE_RUN)) u_mon (
    .clk    (clk),
    .rst_n  (rst_n),
    .linePos(linePos),
    .lineNeg(lineNeg),
    .dataSmp(dataSmp),
    .violSmp(violSmp)
  );

  t1rx_dpath #(.LATENCY(LATENCY), .CHAN_BITS(CHAN_BITS)) u_dpath (
    .clk    (clk),
    .rst_n  (rst_n),
    .dataSmp(dataSmp),
    .violSmp(violSmp),
    .strobe (strobe),
    .serOut (serOut),
    .sigOut (sigOut),
    .linkOut(linkOut),
    .bpvFlag(bpvFlag)
  );

endmodule

// File: rtl/t1_rx_extract_chk.sv
module t1_rx_extract_chk #(
  parameter int FRAME_BITS = 193,
  parameter int CHAN_BITS  = 8,
  parameter int BIT_W      = 8,
  parameter int FRM_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             esfMode,
  input logic [BIT_W-1:0] posBit,
  input logic [FRM_W-1:0] posFrame,
  input logic             serOut,
  input logic             sigOut,
  input logic             linkOut,
  input logic             bpvFlag
);

  // R3: sigOut may only change at a channel MSB.
  a_r3_sig_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !((posBit != '0) && ((32'(posBit) - 1) % CHAN_BITS == 0)) |=> $stable(sigOut));

  // R7: linkOut may only change when serOut takes the last bit of a frame.
  a_r7_link_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(posBit) != FRAME_BITS - 1) |=> $stable(linkOut));

  // R5/R6: the timing inputs stay inside the frame and superframe.
  a_r5_bit_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(posBit) < FRAME_BITS);

  a_r6_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(posFrame) < (esfMode ? 24 : 12));

  // R11: every output is low while reset is held.
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r11_reset_low: assert ({serOut, sigOut, linkOut, bpvFlag} == 4'b0);
    end
  end

endmodule

bind t1_rx_extract t1_rx_extract_chk #(
  .FRAME_BITS(FRAME_BITS), .CHAN_BITS(CHAN_BITS), .BIT_W(BIT_W), .FRM_W(FRM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .esfMode(esfMode), .posBit(posBit),
  .posFrame(posFrame), .serOut(serOut), .sigOut(sigOut),
  .linkOut(linkOut), .bpvFlag(bpvFlag)
);

// File: tb/tb_t1_rx_extract.sv
`timescale 1ns/1ps
module tb_t1_rx_extract;

  localparam int FB  = 193;
  localparam int LAT = 13;
  localparam int TIE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       linePos = 1'b0, lineNeg = 1'b0, esfMode = 1'b0;
  logic [7:0] posBit = '0;
  logic [4:0] posFrame = '0;
  logic       serOut, sigOut, linkOut, bpvFlag;

  int checks = 0;
  int errors = 0;

  t1_rx_extract dut (
    .clk(clk), .rst_n(rst_n), .linePos(linePos), .lineNeg(lineNeg),
    .esfMode(esfMode), .posBit(posBit), .posFrame(posFrame),
    .serOut(serOut), .sigOut(sigOut), .linkOut(linkOut), .bpvFlag(bpvFlag)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input string tag, input logic act, input logic exp, input int cyc);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s period %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  function automatic logic dataBit(input int i);
    if (i == 579 || i == 453) return 1'b1;
    return ((i * 13 + (i / 4) * 7 + 3) % 5) < 2;
  endfunction

  function automatic logic isLinkFrame(input int f, input logic esf);
    return esf ? (f % 2 == 0) : (f % 2 == 1);
  endfunction

  // Link bit held while serOut shows stream index o (R5, R6, R7).
  function automatic logic expLink(input int o, input logic esf);
    int len = esf ? 24 : 12;
    for (int f = (o + 1) / FB; f >= 0; f--) begin
      if (isLinkFrame(f % len, esf)) return dataBit(f * FB);
    end
    return 1'b0;
  endfunction

  // LSB of the channel whose MSB most recently reached serOut (R3, R4).
  function automatic logic expSig(input int o);
    int pb = o % FB;
    if (pb == 0) return dataBit(o - 1);
    return dataBit(o - ((pb - 1) % 8) + 7);
  endfunction

  task automatic applyReset();
    rst_n = 1'b0; linePos = 0; lineNeg = 0; posBit = '0; posFrame = '0;
    repeat (3) @(posedge clk);
    #5;
    check("R11 serOut", serOut, 1'b0, 0);
    check("R11 sigOut", sigOut, 1'b0, 0);
    check("R11 linkOut", linkOut, 1'b0, 0);
    check("R11 bpvFlag", bpvFlag, 1'b0, 0);
    @(posedge clk); #1 rst_n = 1'b1;
  endtask

  // kind 0 clean AMI, 1 repeated-polarity marks, 2 isolated double marks, 3 tied rails.
  task automatic runStream(input logic esf, input int nBits, input int kind);
    int len = esf ? 24 : 12;
    logic lastPol = 1'b0, had = 1'b0, prevViol = 1'b0;
    int tieCnt = 0;
    esfMode = esf;
    applyReset();
    for (int g = 0; g < nBits; g++) begin
      logic d, p, n, v;
      int q, o;
      @(posedge clk);
      #1;
      d = dataBit(g); p = 0; n = 0; v = 0;
      if (d) begin
        if ((kind == 3 && (g < 300 || g == 453)) || (kind == 2 && g % 131 == 60)) begin
          p = 1; n = 1;
          v = (tieCnt < TIE);
          if (tieCnt < TIE) tieCnt++;
        end else begin
          logic same = (kind == 1) && (g % 97 == 50 || g == 579) && had;
          logic pol = same ? lastPol : ~lastPol;
          v = same; p = pol; n = ~pol;
          lastPol = pol; had = 1; tieCnt = 0;
        end
      end
      linePos = p; lineNeg = n;
      q = g - (LAT - 1) + FB * 24;
      posBit = 8'(q % FB);
      posFrame = 5'((q / FB) % len);
      #4;
      o = g - LAT;
      check((kind >= 2) ? "R9/R10 bpvFlag" : "R8 bpvFlag", bpvFlag, prevViol, g);
      prevViol = v;
      if (o < 0) check("R2 serOut pre-fill", serOut, 1'b0, g);
      else       check("R1/R2 serOut", serOut, dataBit(o), g);
      if (o >= 400) begin
        check("R3/R4 sigOut", sigOut, expSig(o), g);
        check(esf ? "R6/R7 linkOut" : "R5/R7 linkOut", linkOut, expLink(o, esf), g);
      end
    end
  endtask

  task automatic testSuperframe();
    runStream(1'b0, 14 * FB, 1);
  endtask

  task automatic testExtended();
    runStream(1'b1, 26 * FB, 0);
  endtask

  task automatic testDoubleMarks();
    runStream(1'b0, 1000, 2);
  endtask

  task automatic testTiedRails();
    runStream(1'b0, 600, 3);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testSuperframe();
    testExtended();
    testDoubleMarks();
    testTiedRails();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule